// File: doc/BRIEF.md
# Rectangular Pixel Transfer Engine

This block moves a rectangle of 16-bit pixels between a 32-bit word stream and a frame memory that is 1024 pixels wide and 512 lines tall. A transfer is started with a position word and a size word, plus a direction bit. Each data word carries two pixels, taken in row-major order across the rectangle. The word stream may pause at any point, including in the middle of a row. The engine keeps its column offset and line and resumes from the same place when the next word arrives.

The frame memory is reached through a plain synchronous RAM port with one cycle of read latency and one pixel per cycle. For writes, the engine accepts a word, then stores its two pixels on consecutive cycles. For reads, each word request fetches two pixels and returns them packed in one word. A status flag stays high for the whole of a read. A one-cycle completion pulse marks the moment the last row has been handled. A write-side cache can use this pulse to refresh the area that was just covered.

Top module: `pixel_xfer_engine`

## Requirements
- R1: The start column is `pos_i[9:0]` and the start line is `pos_i[24:16]`. All other position bits are ignored.
- R2: The width comes from `size_i[9:0]` as ((field−1) mod 1024)+1, and the height from `size_i[24:16]` as ((field−1) mod 512)+1. A zero field therefore gives 1024 columns or 512 lines.
- R3: Pixels are visited row by row, left to right. Within each 32-bit word, bits [15:0] come first and bits [31:16] second. The memory address is line×1024+column, driven as `mem_addr_o = {line[8:0], column[9:0]}`.
- R4: The column wraps modulo 1024 when start column plus offset passes 1023. The line wraps modulo 512 when the rectangle passes line 511.
- R5: Pauses of any length in the word stream, at any pixel position, leave the sequence of addresses and data unchanged.
- R6: `wr_ready_o` is high only during a write transfer with no word held. A word is taken on a cycle with `wr_valid_i` and `wr_ready_o` both high, and its two pixels are written on the next two cycles.
- R7: During a read transfer, `rd_req_i` is taken when `rd_ready_o` is high. The word appears with a one-cycle `rd_valid_o` pulse four cycles after the request edge, low pixel first. If the rectangle ends after the low pixel, bits [31:16] are zero.
- R8: `img_rdy_o` rises when a read transfer starts and falls when the word holding the last pixel is delivered. It stays low during writes.
- R9: When the last pixel of the rectangle is stored or delivered, `done_o` pulses for exactly one cycle and `busy_o` falls.
- R10: When the last pixel is the low half of a word, the high half of that write word is discarded, with no memory write.
- R11: A start during an active transfer abandons the old transfer, with no `done_o` for it, and begins the new one. It also sets `anomaly_o`, which stays high until reset.
- R12: After reset, `busy_o`, `img_rdy_o`, `done_o`, `anomaly_o`, `rd_valid_o`, `mem_we_o` and both ready outputs are low.
- R13: While idle, `wr_valid_i` and `rd_req_i` are ignored: no memory write and no read word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a transfer this cycle |
| start_rd_i | input | 1 | Direction of the started transfer: 1 read, 0 write |
| pos_i | input | 32 | Position word |
| size_i | input | 32 | Size word |
| wr_valid_i | input | 1 | Write word offered |
| wr_data_i | input | 32 | Write word, two pixels |
| wr_ready_o | output | 1 | Engine can take a write word |
| rd_req_i | input | 1 | Request one read word |
| rd_ready_o | output | 1 | Engine can take a read request |
| rd_valid_o | output | 1 | Read word valid pulse |
| rd_data_o | output | 32 | Read word, two pixels |
| mem_addr_o | output | 19 | Frame memory pixel address |
| mem_we_o | output | 1 | Frame memory write enable |
| mem_re_o | output | 1 | Frame memory read enable |
| mem_wdata_o | output | 16 | Frame memory write pixel |
| mem_rdata_i | input | 16 | Frame memory read pixel, one cycle after address |
| busy_o | output | 1 | Transfer active |
| img_rdy_o | output | 1 | Read transfer in progress |
| done_o | output | 1 | Transfer finished pulse |
| anomaly_o | output | 1 | Sticky: a transfer was restarted while active |

## Verification
Two situations are hard to reach from the ports. One is a rectangle that crosses both the right edge and the bottom edge of the frame. The other is a word stream that stops part way through a row. The stimulus table places one rectangle at column 1022 and line 510, and uses a 1024-wide and a 512-tall case to sweep a full wrap in each direction. Every write and read inserts idle gaps after each second word, so pauses land on odd and even offsets inside rows. Odd pixel counts force the last word to end on its low half. A separate directed case restarts a write part way through its first row to reach the abort path.

// File: rtl/pxe_pkg.sv
package pxe_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_WRITE = 2'd1,
        MODE_READ  = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        RPH_WAIT = 2'd0,
        RPH_LO   = 2'd1,
        RPH_HI   = 2'd2,
        RPH_FIN  = 2'd3
    } rphase_e;
endpackage

// File: rtl/pxe_decode.sv
module pxe_decode #(
    parameter int XW = 10,
    parameter int YW = 9,
    parameter int DW = 32
) (
    input  logic [DW-1:0] pos_i,
    input  logic [DW-1:0] size_i,
    output logic [XW-1:0] x_o,
    output logic [YW-1:0] y_o,
    output logic [XW:0]   w_o,
    output logic [YW:0]   h_o
);
    localparam int HLSB = DW / 2;

    logic [XW-1:0] wfield_m1;
    logic [YW-1:0] hfield_m1;

    always_comb begin
        x_o       = pos_i[XW-1:0];
        y_o       = pos_i[HLSB+YW-1:HLSB];
        // minus one within the field width, then plus one: zero means full size
        wfield_m1 = size_i[XW-1:0] - 1'b1;
        hfield_m1 = size_i[HLSB+YW-1:HLSB] - 1'b1;
        w_o       = {1'b0, wfield_m1} + 1'b1;
        h_o       = {1'b0, hfield_m1} + 1'b1;
    end
endmodule

// File: rtl/pxe_cursor.sv
module pxe_cursor #(
    parameter int XW = 10,
    parameter int YW = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [XW-1:0]   x_i,
    input  logic [YW-1:0]   y_i,
    input  logic [XW:0]     w_i,
    input  logic [YW:0]     h_i,
    input  logic            step_i,
    output logic [XW+YW-1:0] addr_o,
    output logic            active_o,
    output logic            last_o
);
    typedef struct packed {
        logic [XW-1:0] x0;
        logic [YW-1:0] line;
        logic [XW:0]   w;
        logic [YW:0]   hrem;
        logic [XW-1:0] off;
    } cur_t;

    cur_t cur_d, cur_q;
    logic row_end;

    always_comb begin
        row_end  = (({1'b0, cur_q.off} + 1'b1) == cur_q.w);
        active_o = (cur_q.hrem != '0);
        last_o   = active_o && (cur_q.hrem == {{YW{1'b0}}, 1'b1}) && row_end;
        addr_o   = {cur_q.line, XW'(cur_q.x0 + cur_q.off)};

        cur_d = cur_q;
        if (load_i) begin
            cur_d.x0   = x_i;
            cur_d.line = y_i;
            cur_d.w    = w_i;
            cur_d.hrem = h_i;
            cur_d.off  = '0;
        end else if (step_i && active_o) begin
            if (row_end) begin
                cur_d.off  = '0;
                cur_d.line = cur_q.line + 1'b1;
                cur_d.hrem = cur_q.hrem - 1'b1;
            end else begin
                cur_d.off  = cur_q.off + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end

    AST_OFF_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |-> ({1'b0, cur_q.off} < cur_q.w)); // R5
    AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && active_o && row_end) |=>
        (cur_q.line == YW'($past(cur_q.line) + 1'b1))); // R4
endmodule

// File: rtl/pixel_xfer_engine.sv
module pixel_xfer_engine
    import pxe_pkg::*;
#(
    parameter int XW = 10,
    parameter int YW = 9,
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             start_rd_i,
    input  logic [DW-1:0]    pos_i,
    input  logic [DW-1:0]    size_i,
    input  logic             wr_valid_i,
    input  logic [DW-1:0]    wr_data_i,
    output logic             wr_ready_o,
    input  logic             rd_req_i,
    output logic             rd_ready_o,
    output logic             rd_valid_o,
    output logic [DW-1:0]    rd_data_o,
    output logic [XW+YW-1:0] mem_addr_o,
    output logic             mem_we_o,
    output logic             mem_re_o,
    output logic [DW/2-1:0]  mem_wdata_o,
    input  logic [DW/2-1:0]  mem_rdata_i,
    output logic             busy_o,
    output logic             img_rdy_o,
    output logic             done_o,
    output logic             anomaly_o
);
    localparam int PW = DW / 2;

    typedef struct packed {
        mode_e         mode;
        rphase_e       rph;
        logic          hold;
        logic          half;
        logic [DW-1:0] word;
        logic [PW-1:0] lo_cap;
        logic          hi_issued;
        logic          rd_valid;
        logic [DW-1:0] rd_word;
        logic          img;
        logic          done;
        logic          anom;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [XW-1:0] dx;
    logic [YW-1:0] dy;
    logic [XW:0]   dw;
    logic [YW:0]   dh;
    logic          cur_step, cur_active, cur_last;

    pxe_decode #(.XW(XW), .YW(YW), .DW(DW)) u_decode (
        .pos_i (pos_i),
        .size_i(size_i),
        .x_o   (dx),
        .y_o   (dy),
        .w_o   (dw),
        .h_o   (dh)
    );

    pxe_cursor #(.XW(XW), .YW(YW)) u_cursor (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (start_i),
        .x_i     (dx),
        .y_i     (dy),
        .w_i     (dw),
        .h_i     (dh),
        .step_i  (cur_step),
        .addr_o  (mem_addr_o),
        .active_o(cur_active),
        .last_o  (cur_last)
    );

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.done     = 1'b0;
        ctl_d.rd_valid = 1'b0;
        cur_step       = 1'b0;
        mem_we_o       = 1'b0;
        mem_re_o       = 1'b0;
        mem_wdata_o    = '0;

        if (start_i) begin
            if (ctl_q.mode != MODE_IDLE) ctl_d.anom = 1'b1;
            ctl_d.mode      = start_rd_i ? MODE_READ : MODE_WRITE;
            ctl_d.rph       = RPH_WAIT;
            ctl_d.hold      = 1'b0;
            ctl_d.half      = 1'b0;
            ctl_d.hi_issued = 1'b0;
            ctl_d.img       = start_rd_i;
        end else begin
            unique case (ctl_q.mode)
                MODE_WRITE: begin
                    if (ctl_q.hold) begin
                        mem_we_o    = 1'b1;
                        mem_wdata_o = ctl_q.half ? ctl_q.word[DW-1:PW] : ctl_q.word[PW-1:0];
                        cur_step    = 1'b1;
                        if (cur_last) begin
                            ctl_d.mode = MODE_IDLE;
                            ctl_d.hold = 1'b0;
                            ctl_d.half = 1'b0;
                            ctl_d.done = 1'b1;
                        end else if (!ctl_q.half) begin
                            ctl_d.half = 1'b1;
                        end else begin
                            ctl_d.hold = 1'b0;
                            ctl_d.half = 1'b0;
                        end
                    end else if (wr_valid_i) begin
                        ctl_d.hold = 1'b1;
                        ctl_d.half = 1'b0;
                        ctl_d.word = wr_data_i;
                    end
                end
                MODE_READ: begin
                    unique case (ctl_q.rph)
                        RPH_WAIT: if (rd_req_i) ctl_d.rph = RPH_LO;
                        RPH_LO: begin
                            mem_re_o        = 1'b1;
                            cur_step        = 1'b1;
                            ctl_d.hi_issued = 1'b0;
                            ctl_d.rph       = RPH_HI;
                        end
                        RPH_HI: begin
                            ctl_d.lo_cap = mem_rdata_i;
                            if (cur_active) begin
                                mem_re_o        = 1'b1;
                                cur_step        = 1'b1;
                                ctl_d.hi_issued = 1'b1;
                            end
                            ctl_d.rph = RPH_FIN;
                        end
                        RPH_FIN: begin
                            ctl_d.rd_valid = 1'b1;
                            ctl_d.rd_word  = {ctl_q.hi_issued ? mem_rdata_i : {PW{1'b0}},
                                              ctl_q.lo_cap};
                            ctl_d.rph      = RPH_WAIT;
                            if (!cur_active) begin
                                ctl_d.mode = MODE_IDLE;
                                ctl_d.img  = 1'b0;
                                ctl_d.done = 1'b1;
                            end
                        end
                        default: ctl_d.rph = RPH_WAIT;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.mode <= MODE_IDLE;
            ctl_q.rph  <= RPH_WAIT;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign wr_ready_o = (ctl_q.mode == MODE_WRITE) && !ctl_q.hold;
    assign rd_ready_o = (ctl_q.mode == MODE_READ) && (ctl_q.rph == RPH_WAIT);
    assign rd_valid_o = ctl_q.rd_valid;
    assign rd_data_o  = ctl_q.rd_word;
    assign busy_o     = (ctl_q.mode != MODE_IDLE);
    assign img_rdy_o  = ctl_q.img;
    assign done_o     = ctl_q.done;
    assign anomaly_o  = ctl_q.anom;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !$past(start_i)) |-> !busy_o); // R9
    AST_WE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (ctl_q.mode == MODE_WRITE)); // R13
    AST_IMG_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        img_rdy_o |-> (ctl_q.mode == MODE_READ)); // R8
    AST_ANOMALY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        anomaly_o |=> anomaly_o); // R11
    AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ready_o && rd_ready_o)); // R6
endmodule

// File: tb/pixel_xfer_engine_test.sv
`timescale 1ns/1ps
module pixel_xfer_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, start_rd_i = 1'b0;
    logic [31:0] pos_i = '0, size_i = '0;
    logic        wr_valid_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic        wr_ready_o, rd_req_i = 1'b0, rd_ready_o, rd_valid_o;
    logic [31:0] rd_data_o;
    logic [18:0] mem_addr_o;
    logic        mem_we_o, mem_re_o;
    logic [15:0] mem_wdata_o, mem_rdata_i;
    logic        busy_o, img_rdy_o, done_o, anomaly_o;

    int tests = 0, fails = 0;
    int done_cnt = 0, we_cnt = 0, rdv_cnt = 0;
    logic [15:0] mem [int];

    always #2 clk = ~clk;

    pixel_xfer_engine uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_rd_i(start_rd_i),
        .pos_i(pos_i), .size_i(size_i), .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i),
        .wr_ready_o(wr_ready_o), .rd_req_i(rd_req_i), .rd_ready_o(rd_ready_o),
        .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .mem_addr_o(mem_addr_o),
        .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .mem_wdata_o(mem_wdata_o),
        .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .img_rdy_o(img_rdy_o),
        .done_o(done_o), .anomaly_o(anomaly_o)
    );

    // synchronous RAM model, one cycle read latency
    always @(posedge clk) begin
        if (mem_we_o) mem[int'(mem_addr_o)] = mem_wdata_o;
        mem_rdata_i <= mem.exists(int'(mem_addr_o)) ? mem[int'(mem_addr_o)] : 16'h0;
    end

    always @(negedge clk) begin
        if (done_o) done_cnt++;
        if (mem_we_o) we_cnt++;
        if (rd_valid_o) rdv_cnt++;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish (actual hung, expected completion)");
        $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic start_xfer(input bit rd, input logic [31:0] p, input logic [31:0] s);
        @(negedge clk);
        start_i = 1'b1; start_rd_i = rd; pos_i = p; size_i = s;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic write_word(input logic [31:0] d);
        for (int t = 0; t < 1000 && !wr_ready_o; t++) @(negedge clk);
        wr_valid_i = 1'b1; wr_data_i = d;
        @(negedge clk);
        wr_valid_i = 1'b0;
    endtask

    task automatic read_word(output logic [31:0] d);
        d = 32'hFFFF_FFFF;
        for (int t = 0; t < 1000 && !rd_ready_o; t++) @(negedge clk);
        rd_req_i = 1'b1;
        @(negedge clk);
        rd_req_i = 1'b0;
        for (int t = 0; t < 20; t++) begin
            if (rd_valid_o) begin d = rd_data_o; break; end
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        for (int t = 0; t < 1000 && busy_o; t++) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [15:0] pv(input int vi, input int k);
        return 16'((vi + 1) * 4096 + k);
    endfunction

    // {pos, size, expected width, expected height}
    localparam logic [95:0] VEC [6] = '{
        {32'h0003_0005, 32'h0002_0004, 16'd4,    16'd2},   // plain rectangle
        {32'h01FE_03FE, 32'h0003_0004, 16'd4,    16'd3},   // right and bottom wrap
        {32'hFE05_FC10, 32'hFC01_F803, 16'd3,    16'd1},   // junk upper bits, odd count
        {32'h0000_0100, 32'h0000_0001, 16'd1,    16'd512}, // height field zero
        {32'h0064_0200, 32'h0001_0000, 16'd1024, 16'd1},   // width field zero
        {32'h0010_0020, 32'h0003_0003, 16'd3,    16'd3}    // odd count, mid-row gaps
    };

    initial begin
        logic [31:0] rw;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(!busy_o && !img_rdy_o, "R12", "busy/img after reset", {busy_o, img_rdy_o}, 0);
        chk(!done_o && !anomaly_o && !rd_valid_o, "R12", "done/anomaly/rd_valid after reset",
            {done_o, anomaly_o, rd_valid_o}, 0);
        chk(!wr_ready_o && !rd_ready_o && !mem_we_o, "R12", "ready/we after reset",
            {wr_ready_o, rd_ready_o, mem_we_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 idle stimulus ignored
        wr_valid_i = 1'b1; rd_req_i = 1'b1; wr_data_i = 32'h1234_5678;
        repeat (4) @(negedge clk);
        wr_valid_i = 1'b0; rd_req_i = 1'b0;
        repeat (6) @(negedge clk);
        chk(we_cnt == 0, "R13", "memory writes while idle", we_cnt, 0);
        chk(rdv_cnt == 0 && !busy_o, "R13", "read words while idle", rdv_cnt, 0);

        for (int vi = 0; vi < 6; vi++) begin
            logic [31:0] p, s;
            int x, y, w, h, n, nw, d0, we0, bad;
            p = VEC[vi][95:64]; s = VEC[vi][63:32];
            w = int'(VEC[vi][31:16]); h = int'(VEC[vi][15:0]);
            x = int'(p[9:0]); y = int'(p[24:16]);
            n = w * h; nw = (n + 1) / 2;
            d0 = done_cnt; we0 = we_cnt;

            start_xfer(1'b0, p, s);
            chk(busy_o && !img_rdy_o, "R8", "write start flags", {busy_o, img_rdy_o}, 2'b10);
            for (int j = 0; j < nw; j++) begin
                logic [15:0] hi;
                hi = (2 * j + 1 < n) ? pv(vi, 2 * j + 1) : 16'hDEAD;
                write_word({hi, pv(vi, 2 * j)});
                if (j % 2 == 1) repeat (3) @(negedge clk); // R5 gaps
            end
            wait_idle();
            chk(done_cnt == d0 + 1 && !busy_o, "R9", "write done pulse", done_cnt - d0, 1);
            chk(we_cnt - we0 == n, "R10", "pixel writes in write", we_cnt - we0, n);
            bad = 0;
            for (int k = 0; k < n; k++) begin
                int a;
                a = ((y + k / w) % 512) * 1024 + ((x + k % w) % 1024);
                if (!mem.exists(a) || mem[a] != pv(vi, k)) bad++;
            end
            chk(bad == 0, "R3", $sformatf("vector %0d stored pixels (R1 R2 R4 R5)", vi), bad, 0);

            d0 = done_cnt;
            start_xfer(1'b1, p, s);
            chk(img_rdy_o && busy_o, "R8", "read start sets image flag", img_rdy_o, 1);
            bad = 0;
            for (int j = 0; j < nw; j++) begin
                logic [31:0] ex;
                ex = {(2 * j + 1 < n) ? pv(vi, 2 * j + 1) : 16'h0000, pv(vi, 2 * j)};
                read_word(rw);
                if (rw != ex) begin
                    bad++;
                    chk(1'b0, "R7", $sformatf("vector %0d word %0d", vi, j), rw, ex);
                end
                if (j % 2 == 1) repeat (2) @(negedge clk);
            end
            chk(bad == 0, "R7", $sformatf("vector %0d read words", vi), bad, 0);
            wait_idle();
            chk(!img_rdy_o && !busy_o, "R8", "image flag cleared after last word", img_rdy_o, 0);
            chk(done_cnt == d0 + 1, "R9", "read done pulse", done_cnt - d0, 1);
        end
        chk(!anomaly_o, "R11", "no anomaly without restart", anomaly_o, 0);

        // R11 restart while active
        begin
            int d0;
            d0 = done_cnt;
            start_xfer(1'b0, 32'h0028_0028, 32'h0002_0004);
            write_word(32'hAAAA_BBBB);
            start_xfer(1'b0, 32'h003C_003C, 32'h0001_0002);
            chk(anomaly_o && busy_o, "R11", "anomaly set on restart", anomaly_o, 1);
            write_word(32'h2222_1111);
            wait_idle();
            chk(done_cnt == d0 + 1, "R11", "single done for restarted pair", done_cnt - d0, 1);
            chk(mem[60 * 1024 + 60] == 16'h1111 && mem[60 * 1024 + 61] == 16'h2222, "R11",
                "new rectangle stored", {mem[60 * 1024 + 61], mem[60 * 1024 + 60]}, 32'h2222_1111);
            repeat (4) @(negedge clk);
            chk(anomaly_o, "R11", "anomaly sticky", anomaly_o, 1);
        end

        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!anomaly_o && !busy_o, "R12", "reset clears anomaly", anomaly_o, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule